// File: doc/BRIEF.md
# Sample-Queued PWM Generator

This block produces a pulse-width-modulated output whose high time is taken, one period at a time, from a small queue of 16-bit duty samples. Software programs a period value, writes duty samples into the queue and sets an enable bit. A free-running counter marks out each period. At every wrap of that counter the generator takes the oldest queued sample as the duty for the period that follows. If the queue is empty, it keeps the duty it already holds.

The queue accepts only one sample fewer than its nominal depth. A write that would fill it is treated as an overrun: the queued samples are discarded and a sticky write-error flag is raised. While that flag stands, the enable bit has no effect and the output stays low. A software reset clears the condition. The reset is requested by setting a control bit, which stays set for a fixed number of cycles and then clears itself. While it is set, the queue is emptied, every flag is cleared and the control fields fall back to zero. A plain single-cycle register port carries all accesses.

Top module: `pwm_fifo_gen`

## Requirements
- R1: While reset is asserted, control reads 0x0, status reads 0x08 (empty, fill 0) and period reads 0x0.
- R2: Register addresses are 0 control, 1 status, 2 period and 3 sample. A write to address 3 queues `reg_wdata[15:0]`. Status bits 2:0 give the number of queued samples, and bit 3 is set exactly when that number is zero.
- R3: A sample write while three samples are queued empties the queue and sets the write-error flag (status bit 6). While the flag is set, sample writes are ignored. With the default period, four sample writes after reset leave status reading 0x58.
- R4: While the write-error flag is set, the output stays low even with enable (control bit 0) set.
- R5: Writing control with bit 3 set starts a software reset. Bit 3 reads back as 1 for four cycles and then reads 0. During that time the other control fields read 0 and writes to control, period and sample are ignored.
- R6: A software reset empties the queue and clears the rollover, compare and write-error flags.
- R7: A period lasts period+1 cycles. The output is high while the counter is below the active duty and low for the rest of the period, so a duty of 0 gives a constant low output.
- R8: At each counter wrap while running, the oldest queued sample becomes the active duty. With an empty queue the previous duty is kept.
- R9: Writing 1 to status bits 4, 5 or 6 clears the matching flag. Writing 0 leaves it unchanged.
- R10: Control bit 0 (enable), bits 17:16 (clock-source select) and bit 22 (debug enable) are stored and read back.
- R11: Status bit 5 is set when the counter equals the active duty while the generator is running.
- R12: Status bit 4 is set at every counter wrap, whether or not the generator is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions check properties that hold on every cycle. The output is never high while the write-error flag stands or while the active duty is zero. The queue is empty whenever the error flag is set and one cycle into any software reset. The enable field stays clear throughout a reset. Some behaviour is only visible in the bench's scenarios, which compare every cycle against a behavioural model and also run directed checks. These cover the exact 0x58 status after an overrun, the number of cycles for which the reset bit reads back as set, the measured high and low times, reuse of the last duty once the queue is empty, and write-one-to-clear on the flags.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_STAT   = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_SAMPLE = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SRST_BIT = 3;
    localparam int CTRL_CLK_LSB  = 16;
    localparam int CTRL_DBG_BIT  = 22;

    localparam int ST_EMPTY_BIT = 3;
    localparam int ST_ROLL_BIT  = 4;
    localparam int ST_CMP_BIT   = 5;
    localparam int ST_ERR_BIT   = 6;

    typedef struct packed {
        logic       dbg;
        logic [1:0] clk_sel;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic err;
        logic cmp;
        logic roll;
    } flags_t;

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic srst);
        logic [REG_W-1:0] v;
        v = '0;
        v[CTRL_EN_BIT]            = c.en;
        v[CTRL_SRST_BIT]          = srst;
        v[CTRL_CLK_LSB +: 2]      = c.clk_sel;
        v[CTRL_DBG_BIT]           = c.dbg;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(flags_t f, logic [2:0] fill);
        logic [REG_W-1:0] v;
        v = '0;
        v[2:0]          = fill;
        v[ST_EMPTY_BIT] = (fill == 3'd0);
        v[ST_ROLL_BIT]  = f.roll;
        v[ST_CMP_BIT]   = f.cmp;
        v[ST_ERR_BIT]   = f.err;
        return v;
    endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [PTR_W-1:0] fill
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            fill <= fill + PTR_W'(push) - PTR_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= din;
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/pwm_wave_unit.sv
module pwm_wave_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] period,
    input  logic [W-1:0] sample,
    input  logic         have_sample,
    output logic         pop,
    output logic         wrap,
    output logic         cmp_hit,
    output logic [W-1:0] duty,
    output logic         pwm_out
);

    logic [W-1:0] cnt;

    assign wrap    = (cnt >= period) && !clear;
    assign pop     = wrap && run && have_sample;
    assign cmp_hit = run && (cnt == duty);
    assign pwm_out = run && (cnt < duty);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            duty <= '0;
        end else begin
            cnt <= wrap ? '0 : cnt + W'(1);
            if (pop) duty <= sample;
        end
    end

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwmgen_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SAMPLE_W    = 16,
    parameter int SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pwm_out
);

    localparam int FILL_W = $clog2(DEPTH);
    localparam int SR_W   = $clog2(SRST_CYCLES + 1);

    ctrl_t               ctrl_q;
    flags_t              flags_q;
    logic [SR_W-1:0]     srst_cnt;
    logic                srst_busy;
    logic [SAMPLE_W-1:0] period_q;
    logic [FILL_W-1:0]   fill;
    logic [SAMPLE_W-1:0] head;
    logic [SAMPLE_W-1:0] duty_cur;
    logic                wr_ctrl, wr_stat, wr_period, push_req;
    logic                overflow, push, pop, wrap, cmp_hit, run;
    flags_t              clr;
    logic                unused_wdata_bits;

    assign srst_busy = (srst_cnt != '0);
    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_period = reg_wr && (reg_addr == ADDR_PERIOD) && !srst_busy;
    assign push_req  = reg_wr && (reg_addr == ADDR_SAMPLE) && !srst_busy && !flags_q.err;
    assign overflow  = push_req && (fill == FILL_W'(DEPTH - 1));
    assign push      = push_req && !overflow;
    assign run       = ctrl_q.en && !flags_q.err && !srst_busy;

    assign clr.roll = wr_stat && reg_wdata[ST_ROLL_BIT];
    assign clr.cmp  = wr_stat && reg_wdata[ST_CMP_BIT];
    assign clr.err  = wr_stat && reg_wdata[ST_ERR_BIT];

    assign unused_wdata_bits = ^{reg_wdata[31:23], reg_wdata[21:18]};

    pwm_sample_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (srst_busy || overflow),
        .push  (push),
        .pop   (pop),
        .din   (reg_wdata[SAMPLE_W-1:0]),
        .dout  (head),
        .fill  (fill)
    );

    pwm_wave_unit #(.W(SAMPLE_W)) u_wave (
        .clk         (clk),
        .rst         (rst),
        .clear       (srst_busy),
        .run         (run),
        .period      (period_q),
        .sample      (head),
        .have_sample (fill != '0),
        .pop         (pop),
        .wrap        (wrap),
        .cmp_hit     (cmp_hit),
        .duty        (duty_cur),
        .pwm_out     (pwm_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            srst_cnt <= '0;
        end else if (srst_busy) begin
            ctrl_q   <= '0;
            srst_cnt <= srst_cnt - SR_W'(1);
        end else if (wr_ctrl) begin
            if (reg_wdata[CTRL_SRST_BIT]) begin
                ctrl_q   <= '0;
                srst_cnt <= SR_W'(SRST_CYCLES);
            end else begin
                ctrl_q.en      <= reg_wdata[CTRL_EN_BIT];
                ctrl_q.clk_sel <= reg_wdata[CTRL_CLK_LSB +: 2];
                ctrl_q.dbg     <= reg_wdata[CTRL_DBG_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst_busy) begin
            flags_q <= '0;
        end else begin
            flags_q.roll <= (flags_q.roll && !clr.roll) || wrap;
            flags_q.cmp  <= (flags_q.cmp  && !clr.cmp)  || cmp_hit;
            flags_q.err  <= (flags_q.err  && !clr.err)  || overflow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            period_q <= '0;
        else if (wr_period) period_q <= reg_wdata[SAMPLE_W-1:0];
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = pack_ctrl(ctrl_q, srst_busy);
            ADDR_STAT:   reg_rdata = pack_status(flags_q, 3'(fill));
            ADDR_PERIOD: reg_rdata = 32'(period_q);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int FILL_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_out,
    input logic              wr_err,
    input logic              srst_busy,
    input logic              en,
    input logic [FILL_W-1:0] fill,
    input logic [W-1:0]      duty
);

    assert_err_queue_empty_R3: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (fill == '0));

    assert_err_blocks_output_R4: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> !pwm_out);

    assert_srst_drops_enable_R5: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> !en);

    assert_srst_flushes_R6: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> (fill == '0) && !wr_err);

    assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm_out);

endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_out   (pwm_out),
    .wr_err    (flags_q.err),
    .srst_busy (srst_busy),
    .en        (ctrl_q.en),
    .fill      (fill),
    .duty      (duty_cur)
);

// File: tb/pwm_fifo_gen_bench.sv
module pwm_fifo_gen_bench;

    localparam int DEPTH = 4;
    localparam int SRST  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_fifo_gen u_pwm_fifo_gen (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    // behavioural reference model
    bit          m_en, m_dbg, m_roll, m_cmp, m_err;
    bit [1:0]    m_clk;
    int          m_srst;
    int          m_period, m_cnt, m_duty;
    int          q[$];
    bit          t_busy, t_wrap, t_run, t_cmp, t_req, t_ovf, t_pop;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_dbg = 0; m_clk = 0; m_srst = 0;
            m_period = 0; m_cnt = 0; m_duty = 0;
            m_roll = 0; m_cmp = 0; m_err = 0;
            q.delete();
        end else begin
            t_busy = (m_srst != 0);
            t_wrap = !t_busy && (m_cnt >= m_period);
            t_run  = m_en && !m_err && !t_busy;
            t_cmp  = t_run && (m_cnt == m_duty);
            t_req  = reg_wr && reg_addr == 2'd3 && !t_busy && !m_err;
            t_ovf  = t_req && (q.size() == DEPTH - 1);
            t_pop  = t_wrap && t_run && (q.size() > 0);
            if (t_busy) begin
                m_cnt = 0; m_duty = 0;
            end else begin
                if (t_pop) m_duty = q.pop_front();
                m_cnt = t_wrap ? 0 : m_cnt + 1;
            end
            if (t_busy || t_ovf) q.delete();
            else if (t_req) q.push_back(int'(reg_wdata[15:0]));
            if (t_busy) begin
                m_roll = 0; m_cmp = 0; m_err = 0;
            end else begin
                m_roll = (m_roll && !(reg_wr && reg_addr == 2'd1 && reg_wdata[4])) || t_wrap;
                m_cmp  = (m_cmp  && !(reg_wr && reg_addr == 2'd1 && reg_wdata[5])) || t_cmp;
                m_err  = (m_err  && !(reg_wr && reg_addr == 2'd1 && reg_wdata[6])) || t_ovf;
            end
            if (t_busy) begin
                m_en = 0; m_clk = 0; m_dbg = 0; m_srst = m_srst - 1;
            end else if (reg_wr && reg_addr == 2'd0) begin
                if (reg_wdata[3]) begin
                    m_srst = SRST; m_en = 0; m_clk = 0; m_dbg = 0;
                end else begin
                    m_en = reg_wdata[0]; m_clk = reg_wdata[17:16]; m_dbg = reg_wdata[22];
                end
            end
            if (reg_wr && reg_addr == 2'd2 && !t_busy) m_period = int'(reg_wdata[15:0]);
        end
    end

    function automatic logic [31:0] model_read(logic [1:0] a);
        logic [31:0] v = '0;
        case (a)
            2'd0: begin
                v[0] = m_en; v[3] = (m_srst != 0); v[17:16] = m_clk; v[22] = m_dbg;
            end
            2'd1: begin
                v[2:0] = 3'(q.size()); v[3] = (q.size() == 0);
                v[4] = m_roll; v[5] = m_cmp; v[6] = m_err;
            end
            2'd2: v = 32'(m_period);
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 pwm_out vs model", pwm_out,
                  (m_en && !m_err && m_srst == 0 && m_cnt < m_duty));
            check("R10 reg_rdata vs model", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        while (!pwm_out && guard < 200) begin @(negedge clk); guard++; end
        hi = 0; lo = 0;
        while (pwm_out && hi < 200) begin hi++; @(negedge clk); end
        while (!pwm_out && lo < 200) begin lo++; @(negedge clk); end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int hi, lo, polls, highs;

        // R1: reset values while reset is held
        repeat (3) @(posedge clk);
        reg_read(2'd0, rd); check("R1 ctrl in reset", rd, 32'h0);
        reg_read(2'd1, rd); check("R1 status in reset", rd, 32'h08);
        reg_read(2'd2, rd); check("R1 period in reset", rd, 32'h0);
        @(posedge clk); #2 rst = 1'b0;

        // R2: fill count
        reg_write(2'd3, 32'd3);
        reg_read(2'd1, rd); check("R2 fill after one write", rd[3:0], 4'h1);
        reg_write(2'd3, 32'd4);
        reg_write(2'd3, 32'd5);
        reg_read(2'd1, rd); check("R2 fill after three writes", rd[3:0], 4'h3);

        // R3: fourth write overruns
        reg_write(2'd3, 32'd6);
        reg_read(2'd1, rd); check("R3 status after overrun", rd, 32'h58);

        // R4: enable refused while the error stands
        reg_write(2'd0, 32'h1);
        highs = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out) highs++; end
        check("R4 output stays low", highs, 0);
        reg_write(2'd3, 32'd9);
        reg_read(2'd1, rd); check("R3 sample ignored while error", rd, 32'h58);

        // R5/R6: software reset
        reg_write(2'd0, 32'h0042_0009);
        polls = 0;
        reg_read(2'd0, rd);
        while (rd[3] && polls < 20) begin
            check("R5 other fields zero during reset", rd & 32'hFFFF_FFF7, 32'h0);
            polls++;
            reg_read(2'd0, rd);
        end
        check("R5 reset-bit polls seen set", polls, SRST - 1);
        check("R5 ctrl after reset", rd, 32'h0);
        reg_read(2'd1, rd); check("R6 queue and error cleared", rd & 32'h4F, 32'h08);

        // R9: write-one-to-clear with a long period
        reg_write(2'd2, 32'd1000);
        reg_read(2'd1, rd); check("R12 rollover flag set", rd[4], 1'b1);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, rd); check("R9 writing 0 keeps flag", rd[4], 1'b1);
        reg_write(2'd1, 32'h70);
        reg_read(2'd1, rd); check("R9 rollover cleared", rd[4], 1'b0);

        // R7/R8: waveform with period 9, duty 3
        reg_write(2'd2, 32'd9);
        reg_write(2'd3, 32'd3);
        reg_write(2'd0, 32'h1);
        @(negedge clk);
        measure(hi, lo);
        check("R7 high time duty 3", hi, 3);
        check("R7 low time duty 3", lo, 7);
        measure(hi, lo);
        check("R8 duty reused high", hi, 3);
        check("R8 duty reused low", lo, 7);
        reg_read(2'd1, rd);
        check("R11 compare flag set", rd[5], 1'b1);
        check("R2 empty after pop", rd[3], 1'b1);

        // R8: new sample taken at a wrap
        reg_write(2'd3, 32'd6);
        repeat (25) @(posedge clk);
        @(negedge clk);
        while (pwm_out) @(negedge clk);
        measure(hi, lo);
        check("R8 new duty high", hi, 6);
        check("R8 new duty low", lo, 4);

        // R7: duty 0 keeps the output low
        reg_write(2'd3, 32'd0);
        repeat (25) @(posedge clk);
        highs = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out) highs++; end
        check("R7 zero duty low", highs, 0);

        // R10: control field readback
        reg_write(2'd0, 32'h0042_0001);
        reg_read(2'd0, rd); check("R10 ctrl readback a", rd, 32'h0042_0001);
        reg_write(2'd0, 32'h0001_0000);
        reg_read(2'd0, rd); check("R10 ctrl readback b", rd, 32'h0001_0000);

        repeat (5) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule